// File: doc/BRIEF.md
# Interrupt Context Frame Sequencer

This block runs the stack traffic that a CPU core needs when it takes an interrupt and when it returns from one. It keeps the code segment register and drives the segment used for instruction fetch. One mode input selects between two stack frame layouts.

In the short layout, entry pushes the program counter and the flags. The interrupt segment register then stands in for the code segment for the whole service routine, and the code segment register is left untouched. In the long layout, entry also pushes the old code segment and then loads the code segment register from the interrupt segment register. This lets a routine reach the whole 22-bit (4 Mbyte) address space, at the cost of one more entry cycle.

The return strobe pops the frame in reverse order and restores the saved values. The layout in force at entry is latched, so the return always unwinds the frame that was actually built. The stack port is a plain synchronous memory port: the byte read by a pop appears one cycle after the pop.

Top module: `irq_frame_seq`

## Requirements
- R1: `irq_ack_o` is high in exactly those cycles where `irq_req_i` is high, `busy_o` is low and no service routine is active. It is combinational in that cycle.
- R2: With `long_frame_i` low in the acknowledge cycle, the three cycles after it each push one byte, in this order: `pc_i[7:0]`, `pc_i[15:8]`, `flags_i`. The values are those sampled in the acknowledge cycle. No fourth push follows.
- R3: With `long_frame_i` high in the acknowledge cycle, a fourth push follows. It carries the code segment held in the acknowledge cycle, zero-extended to 8 bits. From the next cycle on, `csr_o` equals the `isr_i` value seen in that fourth push cycle.
- R4: During a short-frame routine (from the cycle after the last push until `ret_done_o`), `active_seg_o` follows `isr_i`. `csr_o` does not change, and `csr_we_i` is ignored.
- R5: Outside a short-frame routine, `active_seg_o` equals `csr_o`. `csr_we_i` loads `csr_wdata_i` into `csr_o` on the next cycle when `busy_o` is low, and is ignored while `busy_o` is high.
- R6: `iret_i` is taken when `busy_o` is low and a routine is active. The cycles after it pop 3 bytes (short frame) or 4 bytes (long frame), one per cycle. The pops come in reverse push order: segment (long frame only), flags, pc high, pc low.
- R7: `ret_done_o` pulses for one cycle, two cycles after the last pop. From that cycle on, `pc_ret_o` and `flags_ret_o` hold the values that were pushed. In a long frame, `csr_o` takes the low 6 bits of the first popped byte two cycles after that pop.
- R8: The frame layout used on return is the one latched at entry, whatever `long_frame_i` holds later.
- R9: `vec_seg_o` equals `isr_i` in both modes.
- R10: `busy_o` is high from the cycle after acknowledge through the last push, and from the cycle after a taken `iret_i` until `ret_done_o`. Push and pop are never high together. `iret_i` with no active routine has no effect.
- R11: After reset, `busy_o`, `irq_ack_o`, `stk_push_o`, `stk_pop_o` and `ret_done_o` are low, and `csr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| long_frame_i | input | 1 | frame layout select: 1 long, 0 short |
| irq_req_i | input | 1 | interrupt request |
| irq_ack_o | output | 1 | interrupt acknowledge |
| iret_i | input | 1 | return-from-interrupt strobe |
| ret_done_o | output | 1 | return sequence finished, restored values valid |
| busy_o | output | 1 | push or pop sequence in progress |
| pc_i | input | 16 | current program counter |
| flags_i | input | 8 | current flags |
| pc_ret_o | output | 16 | restored program counter |
| flags_ret_o | output | 8 | restored flags |
| csr_we_i | input | 1 | code segment write enable |
| csr_wdata_i | input | 6 | code segment write value |
| csr_o | output | 6 | code segment register |
| isr_i | input | 6 | interrupt segment register |
| vec_seg_o | output | 6 | segment of the vector table |
| active_seg_o | output | 6 | segment used for instruction fetch |
| stk_push_o | output | 1 | stack push |
| stk_pop_o | output | 1 | stack pop |
| stk_wdata_o | output | 8 | byte to push |
| stk_rdata_i | input | 8 | popped byte, valid one cycle after the pop |

## Verification
The bench targets the cases where the latched layout and the live mode input disagree. A design that reads the mode input directly would pop one byte too many or too few and leave the stack misaligned. A segment write inside a short-frame routine must vanish. A design that kept it would change the fetch segment after return. A request held high through a return sequence must be acknowledged only once `ret_done_o` appears. A design that acknowledged early would overlap a push with a pop. Changing the pc and flags right after acknowledge shows whether the frame carries the sampled values rather than the live ones.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_POP, ST_DRAIN} seq_state_e;
  typedef logic [1:0] slot_t;
  // slot numbers give push order; pops run downward
  localparam slot_t SLOT_PCL = 2'd0;
  localparam slot_t SLOT_PCH = 2'd1;
  localparam slot_t SLOT_FLG = 2'd2;
  localparam slot_t SLOT_SEG = 2'd3;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_frame_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  irq_req_i,
  input  logic  iret_i,
  input  logic  long_frame_i,
  input  logic  rcv_vld_i,
  input  slot_t rcv_slot_i,
  output logic  ack_o,
  output logic  push_o,
  output logic  pop_o,
  output logic  busy_o,
  output logic  in_isr_o,
  output logic  mode_l_o,
  output logic  enter_done_o,
  output slot_t slot_o
);
  seq_state_e state_q;
  slot_t      slot_q, top_slot;
  logic       mode_q, in_isr_q, take_ret;

  assign top_slot     = mode_q ? SLOT_SEG : SLOT_FLG;
  assign ack_o        = (state_q == ST_IDLE) && !in_isr_q && irq_req_i;
  assign take_ret     = (state_q == ST_IDLE) && in_isr_q && iret_i;
  assign push_o       = (state_q == ST_PUSH);
  assign pop_o        = (state_q == ST_POP);
  assign busy_o       = (state_q != ST_IDLE);
  assign enter_done_o = push_o && (slot_q == top_slot);
  assign in_isr_o     = in_isr_q;
  assign mode_l_o     = mode_q;
  assign slot_o       = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      slot_q   <= SLOT_PCL;
      mode_q   <= 1'b0;
      in_isr_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ack_o) begin
            state_q <= ST_PUSH;
            slot_q  <= SLOT_PCL;
            mode_q  <= long_frame_i;
          end else if (take_ret) begin
            state_q <= ST_POP;
            slot_q  <= top_slot;
          end
        end
        ST_PUSH: begin
          if (slot_q == top_slot) begin
            state_q  <= ST_IDLE;
            in_isr_q <= 1'b1;
          end else begin
            slot_q <= slot_q + 2'd1;
          end
        end
        ST_POP: begin
          if (slot_q == SLOT_PCL) state_q <= ST_DRAIN;
          else                    slot_q  <= slot_q - 2'd1;
        end
        ST_DRAIN: begin
          if (rcv_vld_i && rcv_slot_i == SLOT_PCL) begin
            state_q  <= ST_IDLE;
            in_isr_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_pack.sv
module frame_pack
  import irq_frame_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEG_W  = 6,
  localparam int PC_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] flags_i,
  input  logic [SEG_W-1:0]  csr_i,
  input  slot_t             slot_i,
  output logic [DATA_W-1:0] wdata_o
);
  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] flg_q;
  logic [SEG_W-1:0]  seg_q;
  logic [DATA_W-1:0] seg_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      flg_q <= '0;
      seg_q <= '0;
    end else if (cap_i) begin
      pc_q  <= pc_i;
      flg_q <= flags_i;
      seg_q <= csr_i;
    end
  end

  generate
    if (SEG_W < DATA_W) begin : g_pad
      assign seg_word = {{(DATA_W - SEG_W){1'b0}}, seg_q};
    end else begin : g_full
      assign seg_word = seg_q;
    end
  endgenerate

  always_comb begin
    case (slot_i)
      SLOT_PCL: wdata_o = pc_q[DATA_W-1:0];
      SLOT_PCH: wdata_o = pc_q[PC_W-1:DATA_W];
      SLOT_FLG: wdata_o = flg_q;
      default:  wdata_o = seg_word;
    endcase
  end
endmodule

// File: rtl/frame_unpack.sv
module frame_unpack
  import irq_frame_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEG_W  = 6,
  localparam int PC_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  slot_t             slot_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              rcv_vld_o,
  output slot_t             rcv_slot_o,
  output logic [PC_W-1:0]   pc_ret_o,
  output logic [DATA_W-1:0] flags_ret_o,
  output logic              done_o,
  output logic              seg_ld_o,
  output logic [SEG_W-1:0]  seg_val_o
);
  logic  vld_q, done_q;
  slot_t slot_q;
  logic [PC_W-1:0]   pc_q;
  logic [DATA_W-1:0] flg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      slot_q <= SLOT_PCL;
      pc_q   <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= pop_i;
      slot_q <= slot_i;
      done_q <= vld_q && (slot_q == SLOT_PCL);
      if (vld_q) begin
        case (slot_q)
          SLOT_PCL: pc_q[DATA_W-1:0]    <= rdata_i;
          SLOT_PCH: pc_q[PC_W-1:DATA_W] <= rdata_i;
          SLOT_FLG: flg_q               <= rdata_i;
          default:  ;
        endcase
      end
    end
  end

  assign rcv_vld_o   = vld_q;
  assign rcv_slot_o  = slot_q;
  assign seg_ld_o    = vld_q && (slot_q == SLOT_SEG);
  assign seg_val_o   = rdata_i[SEG_W-1:0];
  assign pc_ret_o    = pc_q;
  assign flags_ret_o = flg_q;
  assign done_o      = done_q;
endmodule

// File: rtl/seg_ctl.sv
module seg_ctl #(
  parameter int SEG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEG_W-1:0] wdata_i,
  input  logic             enter_ld_i,
  input  logic [SEG_W-1:0] isr_i,
  input  logic             restore_i,
  input  logic [SEG_W-1:0] restore_val_i,
  input  logic             isr_fetch_i,
  output logic [SEG_W-1:0] csr_o,
  output logic [SEG_W-1:0] active_o
);
  logic [SEG_W-1:0] csr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         csr_q <= '0;
    else if (restore_i)  csr_q <= restore_val_i;
    else if (enter_ld_i) csr_q <= isr_i;
    else if (wr_i)       csr_q <= wdata_i;
  end

  assign csr_o    = csr_q;
  assign active_o = isr_fetch_i ? isr_i : csr_q;
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_frame_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEG_W  = 6,
  localparam int PC_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              long_frame_i,
  input  logic              irq_req_i,
  output logic              irq_ack_o,
  input  logic              iret_i,
  output logic              ret_done_o,
  output logic              busy_o,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] flags_i,
  output logic [PC_W-1:0]   pc_ret_o,
  output logic [DATA_W-1:0] flags_ret_o,
  input  logic              csr_we_i,
  input  logic [SEG_W-1:0]  csr_wdata_i,
  output logic [SEG_W-1:0]  csr_o,
  input  logic [SEG_W-1:0]  isr_i,
  output logic [SEG_W-1:0]  vec_seg_o,
  output logic [SEG_W-1:0]  active_seg_o,
  output logic              stk_push_o,
  output logic              stk_pop_o,
  output logic [DATA_W-1:0] stk_wdata_o,
  input  logic [DATA_W-1:0] stk_rdata_i
);
  logic  in_isr, mode_l, enter_done, rcv_vld, seg_ld, short_isr, wr_ok;
  slot_t slot, rcv_slot;
  logic [SEG_W-1:0] seg_val;

  irq_seq_fsm i_fsm (
    .clk_i, .rst_ni, .irq_req_i, .iret_i, .long_frame_i,
    .rcv_vld_i(rcv_vld), .rcv_slot_i(rcv_slot),
    .ack_o(irq_ack_o), .push_o(stk_push_o), .pop_o(stk_pop_o),
    .busy_o, .in_isr_o(in_isr), .mode_l_o(mode_l),
    .enter_done_o(enter_done), .slot_o(slot)
  );

  frame_pack #(.DATA_W(DATA_W), .SEG_W(SEG_W)) i_pack (
    .clk_i, .rst_ni, .cap_i(irq_ack_o), .pc_i, .flags_i,
    .csr_i(csr_o), .slot_i(slot), .wdata_o(stk_wdata_o)
  );

  frame_unpack #(.DATA_W(DATA_W), .SEG_W(SEG_W)) i_unpack (
    .clk_i, .rst_ni, .pop_i(stk_pop_o), .slot_i(slot), .rdata_i(stk_rdata_i),
    .rcv_vld_o(rcv_vld), .rcv_slot_o(rcv_slot), .pc_ret_o, .flags_ret_o,
    .done_o(ret_done_o), .seg_ld_o(seg_ld), .seg_val_o(seg_val)
  );

  assign short_isr = in_isr && !mode_l;
  assign wr_ok     = csr_we_i && !busy_o && !short_isr;

  seg_ctl #(.SEG_W(SEG_W)) i_seg (
    .clk_i, .rst_ni, .wr_i(wr_ok), .wdata_i(csr_wdata_i),
    .enter_ld_i(enter_done && mode_l), .isr_i,
    .restore_i(seg_ld), .restore_val_i(seg_val),
    .isr_fetch_i(short_isr), .csr_o, .active_o(active_seg_o)
  );

  assign vec_seg_o = isr_i;
endmodule

// File: rtl/irq_frame_seq_chk.sv
module irq_frame_seq_chk #(
  parameter int SEG_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_ack_o,
  input logic             busy_o,
  input logic             ret_done_o,
  input logic             stk_push_o,
  input logic             stk_pop_o,
  input logic [SEG_W-1:0] csr_o,
  input logic             in_isr,
  input logic             mode_l
);
  logic       push_d, pop_d;
  logic [2:0] push_cnt, pop_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_d   <= 1'b0;
      pop_d    <= 1'b0;
      push_cnt <= '0;
      pop_cnt  <= '0;
    end else begin
      push_d <= stk_push_o;
      pop_d  <= stk_pop_o;
      if (stk_push_o)      push_cnt <= push_d ? push_cnt + 3'd1 : 3'd1;
      if (stk_pop_o)       pop_cnt  <= pop_d  ? pop_cnt + 3'd1  : 3'd1;
    end
  end

  assert_ack_starts_push_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> (stk_push_o && busy_o));

  assert_no_push_pop_overlap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stk_push_o && stk_pop_o));

  // R2 and R3: frame length follows the latched layout
  assert_push_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_d && !stk_push_o) |-> (push_cnt == (mode_l ? 3'd4 : 3'd3)));

  // R6 with R8: pop count matches the latched layout
  assert_pop_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_d && !stk_pop_o) |-> (pop_cnt == (mode_l ? 3'd4 : 3'd3)));

  assert_csr_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_isr && !mode_l && $past(in_isr)) |-> $stable(csr_o));

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_done_o |-> (!busy_o && !in_isr));
endmodule

bind irq_frame_seq irq_frame_seq_chk #(.SEG_W(SEG_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_ack_o(irq_ack_o), .busy_o(busy_o),
  .ret_done_o(ret_done_o), .stk_push_o(stk_push_o), .stk_pop_o(stk_pop_o),
  .csr_o(csr_o), .in_isr(in_isr), .mode_l(mode_l)
);

// File: tb/test_irq_frame_seq.sv
module test_irq_frame_seq;
  localparam int DW = 8;
  localparam int SW = 6;
  localparam int PW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic long_frame = 1'b0, irq_req = 1'b0, iret = 1'b0, csr_we = 1'b0;
  logic [PW-1:0] pc = '0;
  logic [DW-1:0] flags = '0;
  logic [SW-1:0] csr_wdata = '0, isr = '0;
  logic irq_ack, ret_done, busy, stk_push, stk_pop;
  logic [PW-1:0] pc_ret;
  logic [DW-1:0] flags_ret, stk_wdata;
  logic [DW-1:0] stk_rdata = '0;
  logic [SW-1:0] csr, vec_seg, active_seg;

  int n_cmp = 0, n_bad = 0;
  bit run = 0;

  always #2 clk = ~clk;

  irq_frame_seq #(.DATA_W(DW), .SEG_W(SW)) i_irq_frame_seq (
    .clk_i(clk), .rst_ni(rst_n), .long_frame_i(long_frame), .irq_req_i(irq_req),
    .irq_ack_o(irq_ack), .iret_i(iret), .ret_done_o(ret_done), .busy_o(busy),
    .pc_i(pc), .flags_i(flags), .pc_ret_o(pc_ret), .flags_ret_o(flags_ret),
    .csr_we_i(csr_we), .csr_wdata_i(csr_wdata), .csr_o(csr), .isr_i(isr),
    .vec_seg_o(vec_seg), .active_seg_o(active_seg), .stk_push_o(stk_push),
    .stk_pop_o(stk_pop), .stk_wdata_o(stk_wdata), .stk_rdata_i(stk_rdata)
  );

  // stack memory with one-cycle read
  logic [DW-1:0] mem_q[$];
  always @(posedge clk) begin
    if (stk_push) mem_q.push_back(stk_wdata);
    if (stk_pop) begin
      if (mem_q.size() > 0) stk_rdata <= mem_q.pop_back();
      else                  stk_rdata <= '0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  logic [DW-1:0] exp_q[$];
  bit m_in = 0, m_mode = 0, m_done = 0;
  int pop_left = 0, drain = 0, pops_done = 0;
  logic [SW-1:0] m_csr = '0, m_save = '0;
  logic [PW-1:0] m_pc = '0;
  logic [DW-1:0] m_flg = '0;

  function automatic bit m_busy();
    return (exp_q.size() != 0) || (pop_left != 0) || (drain != 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete(); m_in = 0; m_mode = 0; m_done = 0;
      pop_left = 0; drain = 0; pops_done = 0; m_csr = '0;
    end else begin
      bit idle, ack, wr;
      logic [SW-1:0] nx;
      idle = !m_busy();
      ack  = idle && !m_in && irq_req;
      wr   = idle && csr_we && !(m_in && !m_mode);
      nx   = wr ? csr_wdata : m_csr;
      m_done = 0;
      if (drain != 0) begin
        drain = 0; m_done = 1; m_in = 0;
      end else if (pop_left != 0) begin
        pop_left--; pops_done++;
        if (pops_done == 2 && m_mode) nx = m_save;
        if (pop_left == 0) drain = 1;
      end else if (exp_q.size() != 0) begin
        void'(exp_q.pop_front());
        if (exp_q.size() == 0) begin
          m_in = 1;
          if (m_mode) nx = isr;
        end
      end else if (ack) begin
        m_mode = long_frame; m_pc = pc; m_flg = flags; m_save = m_csr;
        exp_q.push_back(pc[7:0]); exp_q.push_back(pc[15:8]); exp_q.push_back(flags);
        if (long_frame) exp_q.push_back({2'b00, m_csr});
      end else if (iret && m_in) begin
        pop_left = m_mode ? 4 : 3; pops_done = 0;
      end
      m_csr = nx;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      bit b;
      b = m_busy();
      chk("R1", irq_ack, !b && !m_in && irq_req);
      chk("R10", busy, b);
      chk(m_mode ? "R3" : "R2", stk_push, exp_q.size() != 0);
      if (exp_q.size() != 0) chk(m_mode ? "R3" : "R2", stk_wdata, exp_q[0]);
      chk((long_frame != m_mode) ? "R8" : "R6", stk_pop, pop_left != 0);
      chk((m_in && !m_mode) ? "R4" : "R5", active_seg, (m_in && !m_mode) ? isr : m_csr);
      chk((m_in && !m_mode) ? "R4" : "R5", csr, m_csr);
      chk("R7", ret_done, m_done);
      if (m_done) begin
        chk("R7", pc_ret, m_pc);
        chk("R7", flags_ret, m_flg);
      end
      chk("R9", vec_seg, isr);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", busy, 0);
    chk("R11", irq_ack, 0);
    chk("R11", stk_push, 0);
    chk("R11", stk_pop, 0);
    chk("R11", ret_done, 0);
    chk("R11", csr, 0);
    tick(1);
    run = 1;
    // R5 write outside any routine
    csr_we = 1; csr_wdata = 6'h05; tick(1); csr_we = 0;
    // R10 return strobe with no routine is ignored
    iret = 1; tick(1); iret = 0; tick(2);
    // short frame: R2, R4, R8
    long_frame = 0; pc = 16'h1234; flags = 8'h5A; isr = 6'h2A;
    irq_req = 1; tick(1); irq_req = 0; pc = 16'hFFFF; flags = 8'h00;
    tick(5);
    csr_we = 1; csr_wdata = 6'h11; tick(1); csr_we = 0;
    long_frame = 1;
    irq_req = 1; tick(3); irq_req = 0;
    isr = 6'h15; tick(2);
    iret = 1; tick(1); iret = 0; tick(8);
    // long frame: R3, R5, R7, R8
    pc = 16'hABCD; flags = 8'hC3; isr = 6'h33;
    irq_req = 1; tick(1); irq_req = 0; pc = 16'h0F0F;
    tick(6);
    csr_we = 1; csr_wdata = 6'h3E; tick(1); csr_we = 0;
    long_frame = 0; tick(2);
    // request held through return: R10, R1
    pc = 16'h8001; flags = 8'h7E;
    iret = 1; irq_req = 1; tick(1); iret = 0;
    tick(12); irq_req = 0;
    // write attempt during busy and during a short routine
    csr_we = 1; csr_wdata = 6'h01; tick(2); csr_we = 0;
    iret = 1; tick(1); iret = 0; tick(10);
    // ack in same cycle as a write: snapshot uses old segment
    long_frame = 1; csr_we = 1; csr_wdata = 6'h2C; irq_req = 1; tick(1);
    csr_we = 0; irq_req = 0; tick(8);
    iret = 1; tick(1); iret = 0; tick(10);
    run = 0;
    finish_run();
  end
endmodule